// File: doc/BRIEF.md
# X-Capacitor Discharge Detection Sequencer

This block decides whether mains voltage is still reaching the high-voltage sense node of a power supply, or whether the line has been unplugged and the X-capacitor is holding a leftover charge. At a fixed repeat interval it starts a probe attempt. The attempt walks through a window with no test current, then four test-current levels of rising strength. After each step it watches a digital flag from an external comparator, which says that the sensed voltage has dropped below its threshold. A zero crossing of a live line pulls the node down, so when the flag is seen the block reports the line as present and stops probing.

If the flag never appears by the end of the strongest level, the block treats the line as removed. It then drives a discharge-enable output for a fixed time and returns to idle. All timing comes from a 1 ms tick supplied by the surrounding chip, and every duration is a parameter counted in ticks. The defaults are a 700-tick repeat interval, 12-tick steps, a 36-tick final step and a 360-tick discharge. The comparator, the current sources and the discharge switch are outside the block.

Top module: `xcap_probe_seq`

## Requirements
- R1: After a synchronous active-low reset the block is idle: `isel` is 5'b00001 (bit 0 = no test current), `dis_en`, `dis_active` and `ac_present` are 0, and the interval counter is cleared.
- R2: An attempt starts on the first `tick_ms` after reset. Further attempts start every SLOT_MS ticks, and two attempt starts are never less than SLOT_MS ticks apart.
- R3: The first step of an attempt applies no test current (`isel` = 5'b00001) for STEP_MS ticks.
- R4: Without a crossing, the test current escalates in the fixed order I1 (`isel` bit 1), I2 (bit 2), I3 (bit 3), I4 (bit 4). Each of the first three levels lasts STEP_MS ticks, and I4 lasts LAST_MS ticks.
- R5: If `below_thr` is high at a clock edge during any step, then from the next cycle `isel` is 5'b00001, `ac_present` is 1 and the block is idle until the next slot.
- R6: If no crossing is seen by the end of the I4 step, `dis_en` and `dis_active` are high for DIS_MS ticks with `isel` = 5'b00001 and `ac_present` = 0. The block then returns to idle.
- R7: Exactly one bit of `isel` is set in every cycle.
- R8: `below_thr` has no effect while the block is idle or discharging. It neither starts nor ends a phase and does not change `ac_present`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| below_thr | input | 1 | Comparator flag: sensed voltage below threshold |
| isel | output | 5 | One-hot test-current select: bit 0 none, bits 1..4 levels I1..I4 |
| dis_en | output | 1 | Drives the X-capacitor discharge switch |
| ac_present | output | 1 | Line judged present by the most recent attempt |
| dis_active | output | 1 | Discharge phase in progress |

## Verification
On every cycle, assertions check the following. `isel` stays one-hot, and the test current is off while discharging. A comparator hit during a step aborts to idle with the line flagged present. Discharge is entered only from the I4 step. Idle is left only on a slot, and attempt starts are spaced at least the repeat interval apart. The step durations, the escalation order, the discharge length and the ignoring of the flag while idle or discharging can only be shown by the bench. It walks attempts tick by tick, with hits at random and edge positions of each step, and with attempts that run to discharge.

// File: rtl/xps_pkg.sv
// Shared types for the X-capacitor probe sequencer.
// Assumes: probe level index equals the isel bit that the level drives.
package xps_pkg;
    localparam int NUM_LEVELS = 5;   // no current + four test levels

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PROBE0 = 3'd1,
        ST_PROBE1 = 3'd2,
        ST_PROBE2 = 3'd3,
        ST_PROBE3 = 3'd4,
        ST_PROBE4 = 3'd5,
        ST_DRAIN  = 3'd6
    } xps_state_e;
endpackage

// File: rtl/xps_slot_timer.sv
// Repeat-interval timer: pulses slot_go on the tick where its counter is 0,
// so the first pulse comes with the first tick after reset and then every
// SLOT_MS ticks. Assumes tick_ms is a single-cycle pulse.
module xps_slot_timer #(
    parameter int SLOT_MS = 700
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    output logic slot_go
);
    localparam int CW = (SLOT_MS > 1) ? $clog2(SLOT_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOT_MS - 1);

    logic [CW-1:0] cnt;

    // Count ticks modulo SLOT_MS.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick_ms)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    // Slot pulse on the wrap position.
    assign slot_go = tick_ms && (cnt == '0);
endmodule

// File: rtl/xps_dwell_timer.sv
// Step dwell timer: loaded with a tick count on entry to a phase, it counts
// ticks down and flags expire on the tick that ends the phase.
// Assumes load_val is nonzero whenever load is high.
module xps_dwell_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_ms,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic [W-1:0] rem;

    // Load has priority over counting down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rem <= '0;
        else if (load)
            rem <= load_val;
        else if (tick_ms && rem != '0)
            rem <= rem - 1'b1;
    end

    // Last tick of the phase.
    assign expire = tick_ms && (rem == W'(1));

    assert_load_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));
endmodule

// File: rtl/xps_step_fsm.sv
// Phase sequencer: idle -> no-current window -> I1..I4 -> discharge.
// A comparator hit during any probe step ends the attempt with the line
// judged present. Slots that arrive while busy are dropped.
// Assumes slot_go and expire are single-cycle, tick-aligned pulses.
module xps_step_fsm
    import xps_pkg::*;
#(
    parameter int SLOT_MS = 700,
    parameter int STEP_MS = 12,
    parameter int LAST_MS = 36,
    parameter int DIS_MS  = 360,
    parameter int W       = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_ms,
    input  logic         slot_go,
    input  logic         expire,
    input  logic         below_thr,
    output xps_state_e   state,
    output logic         load,
    output logic [W-1:0] load_val,
    output logic         ac_present
);
    localparam int GW = $clog2(SLOT_MS + 1);

    xps_state_e state_nx;
    logic       ac_set, ac_clr;
    logic       probing;

    assign probing = (state >= ST_PROBE0) && (state <= ST_PROBE4);

    // Next phase and dwell reload.
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        load_val = '0;
        ac_set   = 1'b0;
        ac_clr   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (slot_go) begin
                    state_nx = ST_PROBE0;
                    load     = 1'b1;
                    load_val = W'(STEP_MS);
                end
            end
            ST_PROBE0, ST_PROBE1, ST_PROBE2, ST_PROBE3: begin
                if (below_thr) begin
                    state_nx = ST_IDLE;
                    ac_set   = 1'b1;
                end else if (expire) begin
                    state_nx = xps_state_e'(state + 3'd1);
                    load     = 1'b1;
                    load_val = (state == ST_PROBE3) ? W'(LAST_MS) : W'(STEP_MS);
                end
            end
            ST_PROBE4: begin
                if (below_thr) begin
                    state_nx = ST_IDLE;
                    ac_set   = 1'b1;
                end else if (expire) begin
                    state_nx = ST_DRAIN;
                    load     = 1'b1;
                    load_val = W'(DIS_MS);
                    ac_clr   = 1'b1;
                end
            end
            ST_DRAIN: begin
                if (expire)
                    state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Line-present verdict from the last completed attempt.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ac_present <= 1'b0;
        else if (ac_set)
            ac_present <= 1'b1;
        else if (ac_clr)
            ac_present <= 1'b0;
    end

    // Checker state: ticks since the last attempt start (saturating).
    logic [GW-1:0] gap;
    logic          started;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap     <= '0;
            started <= 1'b0;
        end else if (state == ST_IDLE && state_nx == ST_PROBE0) begin
            gap     <= '0;
            started <= 1'b1;
        end else if (tick_ms && gap != GW'(SLOT_MS)) begin
            gap <= gap + 1'b1;
        end
    end

    assert_slot_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && state_nx == ST_PROBE0 && started) |-> (gap >= GW'(SLOT_MS - 1)));

    assert_hit_aborts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (probing && below_thr) |=> (state == ST_IDLE && ac_present));

    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !slot_go) |=> (state == ST_IDLE));

    assert_drain_from_i4_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_DRAIN) |=> (state != ST_DRAIN || $past(state == ST_PROBE4)));
endmodule

// File: rtl/xcap_probe_seq.sv
// Top of the X-capacitor probe sequencer. Wires the repeat-interval timer,
// the dwell timer and the phase sequencer, and decodes the phase into the
// one-hot current select and the discharge outputs.
// Assumes tick_ms is a one-cycle pulse at 1 ms and below_thr is synchronous.
module xcap_probe_seq
    import xps_pkg::*;
#(
    parameter int SLOT_MS = 700,
    parameter int STEP_MS = 12,
    parameter int LAST_MS = 36,
    parameter int DIS_MS  = 360
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_ms,
    input  logic                  below_thr,
    output logic [NUM_LEVELS-1:0] isel,
    output logic                  dis_en,
    output logic                  ac_present,
    output logic                  dis_active
);
    localparam int MAX_A  = (STEP_MS > LAST_MS) ? STEP_MS : LAST_MS;
    localparam int MAX_MS = (MAX_A > DIS_MS) ? MAX_A : DIS_MS;
    localparam int W      = $clog2(MAX_MS + 1);

    logic         slot_go, expire, load;
    logic [W-1:0] load_val;
    xps_state_e   state;

    xps_slot_timer #(.SLOT_MS(SLOT_MS)) u_slot (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .slot_go(slot_go)
    );

    xps_dwell_timer #(.W(W)) u_dwell (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
        .load(load), .load_val(load_val), .expire(expire)
    );

    xps_step_fsm #(
        .SLOT_MS(SLOT_MS), .STEP_MS(STEP_MS), .LAST_MS(LAST_MS),
        .DIS_MS(DIS_MS), .W(W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .slot_go(slot_go),
        .expire(expire), .below_thr(below_thr), .state(state),
        .load(load), .load_val(load_val), .ac_present(ac_present)
    );

    // Current levels 1..4 follow probe phases 1..4.
    for (genvar g = 1; g < NUM_LEVELS; g++) begin : g_lvl
        assign isel[g] = (state == xps_state_e'(int'(ST_PROBE0) + g));
    end
    // No-current select whenever no level is driven.
    assign isel[0] = ~|isel[NUM_LEVELS-1:1];

    assign dis_en     = (state == ST_DRAIN);
    assign dis_active = dis_en;

    assert_isel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(isel) == 1);

    assert_off_in_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dis_en |-> (isel == NUM_LEVELS'(1)));

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (isel == NUM_LEVELS'(1) && !dis_en && !ac_present));
endmodule

// File: tb/xcap_probe_seq_tb.sv
module xcap_probe_seq_tb;
    localparam int SLOT = 60;
    localparam int STEP = 3;
    localparam int LAST = 5;
    localparam int DIS  = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       below_thr = 1'b0;
    logic [4:0] isel;
    logic       dis_en, ac_present, dis_active;

    int checks = 0;
    int errors = 0;
    int used;
    logic exp_ac = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    xcap_probe_seq #(.SLOT_MS(SLOT), .STEP_MS(STEP), .LAST_MS(LAST), .DIS_MS(DIS)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .below_thr(below_thr),
        .isel(isel), .dis_en(dis_en), .ac_present(ac_present), .dis_active(dis_active)
    );

    function automatic int step_len(int k);
        return (k == 4) ? LAST : STEP;
    endfunction

    function automatic logic [4:0] level_sel(int k);
        return 5'b00001 << k;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One millisecond tick lasting one clock; outputs sampled afterwards.
    task automatic do_tick();
        @(negedge clk) tick_ms = 1'b1;
        @(negedge clk) tick_ms = 1'b0;
        used++;
    endtask

    // Comparator pulse for one clock, no tick.
    task automatic pulse_cmp();
        @(negedge clk) below_thr = 1'b1;
        @(negedge clk) below_thr = 1'b0;
    endtask

    task automatic check_idle(string req);
        chk({req, " isel"}, 32'(isel), 32'h1);
        chk({req, " dis_en"}, 32'(dis_en), 32'h0);
        chk({req, " ac_present"}, 32'(ac_present), 32'(exp_ac));
    endtask

    // One attempt: fire_step 0..4 gives a hit at fire_pos within that step,
    // fire_step 5 gives no hit (discharge).
    task automatic run_attempt(int fire_step, int fire_pos);
        bit hit = 1'b0;
        used = 0;
        do_tick();   // slot start (R2)
        for (int k = 0; k < 5 && !hit; k++) begin
            for (int i = 0; i < step_len(k) && !hit; i++) begin
                chk((k == 0) ? "R3 no-current step" : "R4 level order",
                    32'(isel), 32'(level_sel(k)));
                chk("R7 onehot", $countones(isel), 1);
                if (k == fire_step && i == fire_pos) begin
                    pulse_cmp();
                    exp_ac = 1'b1;
                    chk("R5 isel off after hit", 32'(isel), 32'h1);
                    chk("R5 ac_present", 32'(ac_present), 32'h1);
                    chk("R5 no discharge", 32'(dis_en), 32'h0);
                    hit = 1'b1;
                end else begin
                    do_tick();
                end
            end
        end
        if (!hit) begin
            exp_ac = 1'b0;
            for (int i = 0; i < DIS; i++) begin
                chk("R6 dis_en", 32'(dis_en), 32'h1);
                chk("R6 dis_active", 32'(dis_active), 32'h1);
                chk("R6 isel off", 32'(isel), 32'h1);
                chk("R6 ac_present", 32'(ac_present), 32'h0);
                if ($urandom_range(0, 3) == 0) begin
                    pulse_cmp();
                    chk("R8 flag ignored in discharge", 32'(dis_en), 32'h1);
                    chk("R8 ac unchanged in discharge", 32'(ac_present), 32'h0);
                end
                do_tick();
            end
        end
        // Rest of the slot: idle, the flag must not start anything (R2, R8).
        while (used < SLOT) begin
            check_idle("R2 idle between slots");
            if ($urandom_range(0, 7) == 0) begin
                pulse_cmp();
                check_idle("R8 flag ignored in idle");
            end
            do_tick();
        end
        check_idle("R2 idle before next slot");
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check_idle("R1 reset");
        chk("R1 dis_active", 32'(dis_active), 32'h0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset release");

        // Directed corners.
        run_attempt(5, 0);          // full escalation then discharge (R4, R6)
        run_attempt(0, 0);          // hit at the very first sample (R5)
        run_attempt(4, LAST - 1);   // hit at the last I4 sample (R5)
        run_attempt(3, STEP - 1);   // hit at the end of I3
        run_attempt(5, 0);          // discharge again, verdict cleared

        // Random attempts.
        for (int n = 0; n < 20; n++) begin
            int f = $urandom_range(0, 5);
            int p = (f < 5) ? $urandom_range(0, step_len(f) - 1) : 0;
            run_attempt(f, p);
        end

        // Reset in mid-attempt returns to idle (R1).
        used = 0;
        do_tick();
        do_tick();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        exp_ac = 1'b0;
        check_idle("R1 reset mid-attempt");
        used = 0;
        do_tick();
        chk("R2 first tick after reset starts attempt", 32'(isel), 32'h1);
        do_tick();
        do_tick();
        do_tick();
        chk("R4 I1 after reset restart", 32'(isel), 32'h2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #20ms;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule